// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead Time and Decay Patterns

This block drives the four gate controls of one full bridge, made of two legs: leg 1 (high-1, low-1) and leg 2 (high-2, low-2). It takes a current-direction bit, an off-period flag from a chopping current regulator, a recirculation-style select and two enables. From these it forms the set of devices that should conduct. During the on period one diagonal conducts. During the off period the current recirculates in one of two ways. Fast recirculation uses quasi-synchronous rectification: only a low-side device is on. Slow recirculation goes through both upper devices.

Each leg has its own dead-time sequencer. A device that is no longer wanted is released at the next clock edge. A device that is newly wanted is switched on only after `DEAD_CYC` cycles in which the leg's command has not changed. As a result, the two devices of a leg are never on together, and their conduction periods are always separated. The two enables bypass the sequencer and clear all outputs at once, without waiting for a clock edge. One instance serves one bridge.

Top module: `hbg_gate_seq`

## Requirements
- R1: High-1 and low-1 are never on together, and high-2 and low-2 are never on together.
- R2: After a change of a leg's command, a device the command no longer asks for turns off at the first rising edge. A device the command newly asks for stays off through edge `DEAD_CYC` and turns on at edge `DEAD_CYC`+1. Once a leg device turns off, its partner stays off for at least `DEAD_CYC` sampled cycles.
- R3: In the on period (`off_req`=0), `phase`=1 drives high-1 and low-2, and `phase`=0 drives high-2 and low-1.
- R4: In fast recirculation, the conducting devices turn off and, after the dead time, only one low-side device turns on: low-1 for `phase`=1, low-2 for `phase`=0. No high-side device turns on while fast recirculation is commanded.
- R5: In slow recirculation, only the conducting low-side device turns off. The conducting high-side device stays on without a gap, and the opposite high-side device turns on after the dead time.
- R6: `decay_sel`=0 selects fast recirculation and `decay_sel`=1 selects slow recirculation.
- R7: At the end of the off period, the on-period diagonal returns only after the dead time.
- R8: A `phase` change during the on period passes through `DEAD_CYC` cycles with all four gates off before the new diagonal turns on.
- R9: `en_all`=0 forces all four gates off in the same cycle, without a clock edge. After it returns high, devices come on only after the dead time.
- R10: `br_en`=0 behaves exactly like `en_all`=0.
- R11: While `rst_n` is low at a rising edge, all gates are off. After release, the commanded devices come on after the dead time.
- R12: A further change of a leg's command while that leg is waiting restarts its dead time from the new change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_all | input | 1 | Global enable; low clears all gates at once |
| br_en | input | 1 | Enable for this bridge only |
| phase | input | 1 | Current direction: 1 = high-1/low-2 diagonal |
| off_req | input | 1 | Off period requested by the current chopper |
| decay_sel | input | 1 | Recirculation style: 0 fast, 1 slow |
| gate_h1 | output | 1 | Leg 1 high-side gate |
| gate_l1 | output | 1 | Leg 1 low-side gate |
| gate_h2 | output | 1 | Leg 2 high-side gate |
| gate_l2 | output | 1 | Leg 2 low-side gate |

## Verification
The hard case is a second command change landing on the same edge as, or inside, a dead-time countdown that is already running. Examples are a `phase` flip arriving together with the start of an off period, or an enable dropping midway through the wait. The bench provokes this with directed restarts one or two cycles into a wait, and with random input changes at a rate that often overlaps windows. It judges every cycle against a per-leg model written from R2 and R12, which says when each wanted device may turn on. The bound checker watches the leg gaps independently.

// File: rtl/hbg_pkg.sv
// Shared definitions for the full-bridge gate sequencer.
// Assumes two legs per bridge; each leg command is a 2-bit {high, low} pair.
package hbg_pkg;
    localparam int LEGS   = 2;
    localparam int HI_BIT = 1;
    localparam int LO_BIT = 0;

    typedef enum logic {
        DECAY_FAST = 1'b0,
        DECAY_SLOW = 1'b1
    } decay_e;
endpackage

// File: rtl/hbg_pattern.sv
// Decodes the bridge command into the wanted conduction pattern per leg.
// Purely combinational; assumes the caller folds both enables into 'enable'.
module hbg_pattern
    import hbg_pkg::*;
(
    input  logic                     phase,
    input  logic                     off_req,
    input  logic                     decay_sel,
    input  logic                     enable,
    output logic [LEGS-1:0][1:0]     leg_cmd
);
    // Select diagonal, fast-recirculation low side, or upper recirculation.
    always_comb begin
        leg_cmd = '0;
        if (enable) begin
            if (!off_req) begin
                leg_cmd[0][HI_BIT] = phase;
                leg_cmd[0][LO_BIT] = !phase;
                leg_cmd[1][HI_BIT] = !phase;
                leg_cmd[1][LO_BIT] = phase;
            end else if (decay_e'(decay_sel) == DECAY_SLOW) begin
                leg_cmd[0][HI_BIT] = 1'b1;
                leg_cmd[1][HI_BIT] = 1'b1;
            end else begin
                leg_cmd[0][LO_BIT] = phase;
                leg_cmd[1][LO_BIT] = !phase;
            end
        end
    end
endmodule

// File: rtl/hbg_leg_dt.sv
// Dead-time sequencer for one bridge leg.
// Unwanted devices drop at the next edge; newly wanted devices wait DEAD_CYC
// edges of a stable command. Assumes DEAD_CYC >= 1 and a one-hot-or-zero command.
module hbg_leg_dt #(
    parameter int DEAD_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd,
    output logic [1:0] drv
);
    localparam int CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;

    logic [1:0]       seen_q;
    logic [1:0]       drv_q;
    logic [CNT_W-1:0] wait_q;

    // Track command, release dropped devices, count down before switching on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            drv_q  <= '0;
            wait_q <= '0;
        end else if (cmd != seen_q) begin
            seen_q <= cmd;
            drv_q  <= drv_q & cmd;
            wait_q <= CNT_W'(DEAD_CYC - 1);
        end else if (wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end else begin
            drv_q  <= cmd;
        end
    end

    assign drv = drv_q;
endmodule

// File: rtl/hbg_gate_seq.sv
// Full-bridge gate sequencer: command decode, per-leg dead time, enable kill.
// Enables act combinationally on the outputs so a disable needs no clock edge.
module hbg_gate_seq
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_all,
    input  logic br_en,
    input  logic phase,
    input  logic off_req,
    input  logic decay_sel,
    output logic gate_h1,
    output logic gate_l1,
    output logic gate_h2,
    output logic gate_l2
);
    logic                 en_ok;
    logic [LEGS-1:0][1:0] leg_cmd;
    logic [LEGS-1:0][1:0] leg_drv;

    assign en_ok = en_all & br_en;

    hbg_pattern u_pat (
        .phase     (phase),
        .off_req   (off_req),
        .decay_sel (decay_sel),
        .enable    (en_ok),
        .leg_cmd   (leg_cmd)
    );

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        hbg_leg_dt #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (leg_cmd[g]),
            .drv   (leg_drv[g])
        );
    end

    assign gate_h1 = leg_drv[0][HI_BIT] & en_ok;
    assign gate_l1 = leg_drv[0][LO_BIT] & en_ok;
    assign gate_h2 = leg_drv[1][HI_BIT] & en_ok;
    assign gate_l2 = leg_drv[1][LO_BIT] & en_ok;
endmodule

// File: rtl/hbg_gate_seq_chk.sv
// Property checker for hbg_gate_seq, attached through bind below.
// Measures per-leg off gaps with saturating counters instead of deep $past.
module hbg_gate_seq_chk #(
    parameter int DEAD_CYC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic en_all,
    input logic br_en,
    input logic off_req,
    input logic decay_sel,
    input logic gate_h1,
    input logic gate_l1,
    input logic gate_h2,
    input logic gate_l2
);
    logic [1:0] leg_hi;
    logic [1:0] leg_lo;
    logic [1:0] seen_on;
    logic [1:0] last_hi;
    int         gap [2];

    assign leg_hi = {gate_h2, gate_h1};
    assign leg_lo = {gate_l2, gate_l1};

    // Count all-off cycles per leg and remember which device conducted last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_on <= '0;
            last_hi <= '0;
            gap[0]  <= 0;
            gap[1]  <= 0;
        end else begin
            for (int i = 0; i < 2; i++) begin
                if (leg_hi[i] || leg_lo[i]) begin
                    gap[i]     <= 0;
                    seen_on[i] <= 1'b1;
                    last_hi[i] <= leg_hi[i];
                end else if (gap[i] < DEAD_CYC) begin
                    gap[i] <= gap[i] + 1;
                end
            end
        end
    end

    AST_LEG1_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(gate_h1 && gate_l1)); // R1
    AST_LEG2_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(gate_h2 && gate_l2)); // R1
    AST_GAP_H1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_h1) && seen_on[0] && !last_hi[0]) |-> (gap[0] >= DEAD_CYC)); // R2
    AST_GAP_L1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_l1) && seen_on[0] && last_hi[0]) |-> (gap[0] >= DEAD_CYC)); // R2
    AST_GAP_H2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_h2) && seen_on[1] && !last_hi[1]) |-> (gap[1] >= DEAD_CYC)); // R2
    AST_GAP_L2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_l2) && seen_on[1] && last_hi[1]) |-> (gap[1] >= DEAD_CYC)); // R2
    AST_FAST_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gate_h1) || $rose(gate_h2)) |-> !($past(off_req) && !$past(decay_sel))); // R4
    AST_GLOBAL_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        !en_all |-> !(gate_h1 || gate_l1 || gate_h2 || gate_l2)); // R9
    AST_BRIDGE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        !br_en |-> !(gate_h1 || gate_l1 || gate_h2 || gate_l2)); // R10
endmodule

bind hbg_gate_seq hbg_gate_seq_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_all    (en_all),
    .br_en     (br_en),
    .off_req   (off_req),
    .decay_sel (decay_sel),
    .gate_h1   (gate_h1),
    .gate_l1   (gate_l1),
    .gate_h2   (gate_h2),
    .gate_l2   (gate_l2)
);

// File: tb/hbg_gate_seq_tb.sv
// Bench for hbg_gate_seq: directed corner cases, then seeded random commands
// checked every cycle against a per-leg model built from R2 and R12.
module hbg_gate_seq_tb;
    localparam int CLK_P = 10;
    localparam int DEAD  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_all = 1'b1, br_en = 1'b1, phase = 1'b1, off_req = 1'b0, decay_sel = 1'b0;
    logic gate_h1, gate_l1, gate_h2, gate_l2;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [1:0] m_seen [2];
    logic [1:0] m_out  [2];
    int         m_wait [2];

    always #(CLK_P/2) clk = ~clk;

    hbg_gate_seq #(.DEAD_CYC(DEAD)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_all(en_all), .br_en(br_en),
        .phase(phase), .off_req(off_req), .decay_sel(decay_sel),
        .gate_h1(gate_h1), .gate_l1(gate_l1), .gate_h2(gate_h2), .gate_l2(gate_l2)
    );

    // Wanted {hi,lo} of a leg from R3, R4, R5, R6, R9, R10.
    function automatic logic [1:0] want(input int leg);
        logic [1:0] w;
        w = 2'b00;
        if (en_all && br_en) begin
            if (!off_req)       w = (leg == 0) ? {phase, !phase} : {!phase, phase};
            else if (decay_sel) w = 2'b10;
            else                w = (leg == 0) ? {1'b0, phase} : {1'b0, !phase};
        end
        return w;
    endfunction

    function automatic logic [3:0] model_gates();
        logic [3:0] g;
        g = {m_out[0], m_out[1]};
        if (!(en_all && br_en)) g = 4'b0000;
        return g;
    endfunction

    task automatic model_edge();
        for (int l = 0; l < 2; l++) begin
            if (!rst_n) begin
                m_seen[l] = 2'b00; m_out[l] = 2'b00; m_wait[l] = 0;
            end else if (want(l) != m_seen[l]) begin
                m_seen[l] = want(l); m_out[l] = m_out[l] & want(l); m_wait[l] = DEAD - 1;
            end else if (m_wait[l] > 0) begin
                m_wait[l] = m_wait[l] - 1;
            end else begin
                m_out[l] = want(l);
            end
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
        end
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] exp_g);
        logic [3:0] act;
        act = {gate_h1, gate_l1, gate_h2, gate_l2};
        total++;
        if (act !== exp_g) begin
            bad++;
            $display("FAIL %s act=%b exp=%b (h1 l1 h2 l2) t=%0t", req, act, exp_g, $time);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4711);
        tick(3);
        check("R11 reset", 4'b0000);
        // Release with on-period command, phase 1
        rst_n = 1'b1;
        tick(DEAD);     check("R11 wait", 4'b0000);
        tick(1);        check("R3 phase1 diagonal", 4'b1001);
        // Slow recirculation
        off_req = 1'b1; decay_sel = 1'b1;
        tick(1);        check("R5 low drop", 4'b1000);
        tick(DEAD - 1); check("R5 hold", 4'b1000);
        tick(1);        check("R5 upper pair R6", 4'b1010);
        // Back to on period
        off_req = 1'b0;
        tick(1);        check("R7 release", 4'b1000);
        tick(DEAD);     check("R7 diag back", 4'b1001);
        // Fast recirculation
        decay_sel = 1'b0; off_req = 1'b1;
        tick(1);        check("R4 all off", 4'b0000);
        tick(DEAD);     check("R4 low1 only R6", 4'b0100);
        off_req = 1'b0;
        tick(1);        check("R7 off", 4'b0000);
        tick(DEAD);     check("R7 diag", 4'b1001);
        // Phase reversal in on period
        phase = 1'b0;
        tick(1);        check("R8 all off", 4'b0000);
        tick(DEAD - 1); check("R8 still off", 4'b0000);
        tick(1);        check("R8 new diag", 4'b0110);
        off_req = 1'b1;
        tick(1);        check("R4 phase0 off", 4'b0000);
        tick(DEAD);     check("R4 low2 only", 4'b0001);
        // Global enable kill, no edge needed
        en_all = 1'b0; #1;
        check("R9 immediate", 4'b0000);
        tick(1);
        en_all = 1'b1;
        tick(DEAD);     check("R9 wait", 4'b0000);
        tick(1);        check("R9 resume", 4'b0001);
        // Bridge enable kill
        br_en = 1'b0; #1;
        check("R10 immediate", 4'b0000);
        tick(1);
        br_en = 1'b1;
        tick(DEAD);     check("R10 wait", 4'b0000);
        tick(1);        check("R10 resume", 4'b0001);
        // Restart of the wait
        off_req = 1'b0;
        tick(2);        check("R12 mid wait", 4'b0000);
        phase = 1'b1;
        tick(DEAD);     check("R12 restarted", 4'b0000);
        tick(1);        check("R12 done", 4'b1001);

        // Seeded random commands, checked every cycle
        for (int c = 0; c < 3000; c++) begin
            int unsigned r;
            r = $urandom;
            if (r[2:0] == 3'd0) phase = ~phase;
            if (r[5:3] == 3'd0) off_req = ~off_req;
            if (r[8:6] == 3'd1) decay_sel = ~decay_sel;
            if (r[13:9] == 5'd0) en_all = 1'b0; else if (r[13:9] > 5'd3) en_all = 1'b1;
            if (r[18:14] == 5'd0) br_en = 1'b0; else if (r[18:14] > 5'd3) br_en = 1'b1;
            if (r[23:19] == 5'd2) begin phase = ~phase; off_req = ~off_req; end
            #1;
            check("R9 R10 comb", model_gates());
            tick(1);
            check("R2 random", model_gates());
            if ((gate_h1 && gate_l1) || (gate_h2 && gate_l2)) check("R1 leg overlap", 4'b0000);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule